// File: doc/BRIEF.md
# Ping-Pong Repeater Stage

This block is one stage of a pipelined repeater for a long on-chip route. It holds two copies of the data register, called the top lane and the bottom lane, and each lane has its own handshake control. After a lane captures a word, it spends a fixed acknowledge interval of `ACK_LAT` cycles before it can capture again. While one lane waits out that interval, the other lane can take the next word, so the data wires carry work during the acknowledge time instead of sitting idle.

A write token and a read token each pass between the two lanes on every transfer, and both start at the top lane. Each lane can therefore capture only when it is its turn and emit only when it is its turn. Because of this, a word can never overwrite the other lane's word, and words leave the stage in the order they arrived. A single multiplexer, steered by the read token, drives the shared output bus.

Both sides use a valid/ready handshake. Setting `DUAL` to 0 builds the one-lane version, which serves as a baseline for throughput.

Top module: `pingpong_repeater`

## Requirements
- R1: After reset the stage is empty: `out_valid` is 0 and `in_ready` is 1, and the write token and the read token both point to the top lane.
- R2: A word is captured on a clock edge where `in_valid` and `in_ready` are both 1. It is removed on an edge where `out_valid` and `out_ready` are both 1. `out_valid` is 1 only while the lane selected by the read token holds a word.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` keeps its value on the next cycle.
- R4: The sequence of words leaving the stage is exactly the sequence that entered, with nothing lost, duplicated or overwritten, under any pattern of input gaps and output stalls.
- R5: Captures alternate strictly between the lanes, and so do emissions. Each token moves to the other lane on every transfer on its side. With continuous input and no output stall and `ACK_LAT` = 2, the gaps between successive captures alternate between 1 and 2 cycles.
- R6: A lane that captures a word cannot capture again during the next `ACK_LAT` cycles. In the one-lane build with no output stall, captures are exactly `ACK_LAT`+1 cycles apart.
- R7: With continuous input and no output stall, the two-lane build captures two words every `ACK_LAT`+1 cycles. This is twice the rate of the one-lane build (200 versus 100 words in 300 cycles for `ACK_LAT` = 2, within one word).
- R8: With `out_ready` held at 0, the two-lane build captures exactly two words and the one-lane build exactly one, after which `in_ready` stays 0.
- R9: A word captured into an empty stage appears on `out_data` with `out_valid` = 1 in the cycle right after the capture edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream has a word |
| in_ready | output | 1 | The lane that holds the write token can capture |
| in_data | input | DATA_W | Incoming word |
| out_valid | output | 1 | The lane that holds the read token has a word |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | DATA_W | Word from the lane that holds the read token |

## Verification
The bench drives a two-lane instance and a one-lane instance side by side and checks both against bench queues.

- Token out of step: if a token fails to move, or moves on the wrong side, one lane's word would be emitted twice or overwritten. The order check catches both.
- Latency count off by one: the one-lane capture spacing and the 1/2 alternation in the two-lane stream would show an off-by-one error in the acknowledge counter. The two-lane versus one-lane word counts over a long stream would show a lost doubling.
- Wrong capacity: a full-stall run detects a stage that captures a third word or only one.
- Unstable stalls: stall cycles detect output data that changes while it waits.

// File: rtl/prp_pkg.sv
`timescale 1ns/1ps
package prp_pkg;

  typedef enum logic {
    LANE_TOP = 1'b0,
    LANE_BOT = 1'b1
  } lane_e;

  function automatic int cnt_width(input int lat);
    return (lat < 1) ? 1 : $clog2(lat + 1);
  endfunction

  function automatic lane_e other_lane(input lane_e l);
    return (l == LANE_TOP) ? LANE_BOT : LANE_TOP;
  endfunction

endpackage

// File: rtl/prp_lane.sv
`timescale 1ns/1ps
// One lane: a data register captured unconditionally on take, an occupancy
// flag, and an acknowledge countdown that blocks the next capture.
module prp_lane #(
  parameter int DATA_W  = 32,
  parameter int ACK_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              drain,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              full,
  output logic              idle
);
  localparam int CW = prp_pkg::cnt_width(ACK_LAT);

  logic [CW-1:0] ack_cnt;

  // data register: no reset so it maps onto plain fabric registers
  always_ff @(posedge clk) begin
    if (take) dout <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full    <= 1'b0;
      ack_cnt <= '0;
    end else begin
      if (take)       full <= 1'b1;
      else if (drain) full <= 1'b0;

      if (take)                 ack_cnt <= CW'(ACK_LAT);
      else if (ack_cnt != '0)   ack_cnt <= ack_cnt - 1'b1;
    end
  end

  assign idle = !full && (ack_cnt == '0);

endmodule

// File: rtl/prp_token.sv
`timescale 1ns/1ps
// Turn token: names the lane whose turn it is; passes on every advance.
module prp_token #(
  parameter int LANES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output prp_pkg::lane_e sel
);
  generate
    if (LANES > 1) begin : g_turn
      always_ff @(posedge clk) begin
        if (rst)      sel <= prp_pkg::LANE_TOP;
        else if (adv) sel <= prp_pkg::other_lane(sel);
      end
    end else begin : g_fixed
      assign sel = prp_pkg::LANE_TOP;
    end
  endgenerate
endmodule

// File: rtl/prp_outmux.sv
`timescale 1ns/1ps
// Shared output bus: only the lane holding the read token drives it.
module prp_outmux #(
  parameter int DATA_W = 32
) (
  input  prp_pkg::lane_e     sel,
  input  logic [DATA_W-1:0] d_top,
  input  logic [DATA_W-1:0] d_bot,
  input  logic               full_top,
  input  logic               full_bot,
  output logic               valid,
  output logic [DATA_W-1:0] data
);
  always_comb begin
    if (sel == prp_pkg::LANE_BOT) begin
      valid = full_bot;
      data  = d_bot;
    end else begin
      valid = full_top;
      data  = d_top;
    end
  end
endmodule

// File: rtl/pingpong_repeater.sv
`timescale 1ns/1ps
module pingpong_repeater #(
  parameter int DATA_W  = 32,
  parameter int ACK_LAT = 2,
  parameter bit DUAL    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  import prp_pkg::*;

  localparam int LANES = DUAL ? 2 : 1;

  lane_e             wr_sel;
  lane_e             rd_sel;
  logic [1:0]        lane_full;
  logic [1:0]        lane_idle;
  logic [1:0]        lane_take;
  logic [1:0]        lane_drain;
  logic [DATA_W-1:0] lane_q [2];
  logic              accept;
  logic              emit;

  assign in_ready = lane_idle[wr_sel];
  assign accept   = in_valid && in_ready;
  assign emit     = out_valid && out_ready;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      assign lane_take[g]  = accept && (wr_sel == lane_e'(1'(g)));
      assign lane_drain[g] = emit   && (rd_sel == lane_e'(1'(g)));
      if (g < LANES) begin : g_live
        prp_lane #(
          .DATA_W (DATA_W),
          .ACK_LAT(ACK_LAT)
        ) u_lane (
          .clk  (clk),
          .rst  (rst),
          .take (lane_take[g]),
          .drain(lane_drain[g]),
          .din  (in_data),
          .dout (lane_q[g]),
          .full (lane_full[g]),
          .idle (lane_idle[g])
        );
      end else begin : g_absent
        assign lane_q[g]    = '0;
        assign lane_full[g] = 1'b0;
        assign lane_idle[g] = 1'b0;
      end
    end
  endgenerate

  prp_token #(.LANES(LANES)) u_wr_tok (
    .clk(clk), .rst(rst), .adv(accept), .sel(wr_sel)
  );

  prp_token #(.LANES(LANES)) u_rd_tok (
    .clk(clk), .rst(rst), .adv(emit), .sel(rd_sel)
  );

  prp_outmux #(.DATA_W(DATA_W)) u_mux (
    .sel     (rd_sel),
    .d_top   (lane_q[0]),
    .d_bot   (lane_q[1]),
    .full_top(lane_full[0]),
    .full_bot(lane_full[1]),
    .valid   (out_valid),
    .data    (out_data)
  );

endmodule

// File: rtl/prp_checker.sv
`timescale 1ns/1ps
module prp_checker #(
  parameter int DATA_W  = 32,
  parameter int ACK_LAT = 2,
  parameter int LANES   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input prp_pkg::lane_e    wr_sel,
  input prp_pkg::lane_e    rd_sel,
  input logic [1:0]        lane_full
);
  // R1
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && in_ready && wr_sel == prp_pkg::LANE_TOP
                    && rd_sel == prp_pkg::LANE_TOP));

  // R2
  a_r2_valid_needs_word: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> lane_full[rd_sel]);

  // R3
  a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5
  a_r5_wr_token_passes: assert property (@(posedge clk) disable iff (rst)
    (LANES > 1 && in_valid && in_ready) |=> (wr_sel != $past(wr_sel)));

  // R5
  a_r5_rd_token_passes: assert property (@(posedge clk) disable iff (rst)
    (LANES > 1 && out_valid && out_ready) |=> (rd_sel != $past(rd_sel)));

  // R6
  a_r6_single_lane_gap: assert property (@(posedge clk) disable iff (rst)
    (LANES == 1 && ACK_LAT > 0 && in_valid && in_ready) |=> !in_ready);

  // R8
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !lane_full[wr_sel]);
endmodule

bind pingpong_repeater prp_checker #(
  .DATA_W (DATA_W),
  .ACK_LAT(ACK_LAT),
  .LANES  (LANES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .wr_sel   (wr_sel),
  .rd_sel   (rd_sel),
  .lane_full(lane_full)
);

// File: tb/sim_pingpong_repeater.sv
`timescale 1ns/1ps
module sim_pingpong_repeater;
  localparam int W   = 32;
  localparam int LAT = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ivld [2];
  logic         irdy [2];
  logic [W-1:0] idata[2];
  logic         ovld [2];
  logic         ordy [2];
  logic [W-1:0] odata[2];

  always #10 clk = ~clk;

  // index 0: two-lane stage, index 1: one-lane baseline
  pingpong_repeater #(.DATA_W(W), .ACK_LAT(LAT), .DUAL(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(ivld[0]), .in_ready(irdy[0]),
    .in_data(idata[0]), .out_valid(ovld[0]), .out_ready(ordy[0]),
    .out_data(odata[0]));

  pingpong_repeater #(.DATA_W(W), .ACK_LAT(LAT), .DUAL(1'b0)) u1 (
    .clk(clk), .rst(rst), .in_valid(ivld[1]), .in_ready(irdy[1]),
    .in_data(idata[1]), .out_valid(ovld[1]), .out_ready(ordy[1]),
    .out_data(odata[1]));

  int           tests = 0;
  int           fails = 0;
  int           cyc   = 0;
  bit           src_on = 1'b1;
  bit           chk_iv = 1'b0;
  logic [W-1:0] expq [2][$];
  int unsigned  seq  [2];
  bit           acc_now [2];
  bit           held [2];
  logic [W-1:0] hdata[2];
  bit           lat_pend[2];
  logic [W-1:0] lat_word[2];
  int           lastc[2];
  int           lastd[2];
  int           accn [2];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] word_of(input int unsigned s, input int k);
    return W'(s * 32'h9E37_79B1 + 32'h0000_1234 + k);
  endfunction

  task automatic step(input int vpct, input int rpct);
    @(negedge clk);
    cyc++;
    for (int k = 0; k < 2; k++) begin
      if (acc_now[k]) ivld[k] = 1'b0;
      acc_now[k] = 1'b0;
      if (!ivld[k] && src_on && ($urandom % 100) < vpct) begin
        ivld[k]  = 1'b1;
        idata[k] = word_of(seq[k], k);
        seq[k]++;
      end
      ordy[k] = (($urandom % 100) < rpct);
    end
    #5;
    for (int k = 0; k < 2; k++) begin
      if (held[k])
        chk(ovld[k] && odata[k] == hdata[k], "R3", "stalled word held",
            longint'(odata[k]), longint'(hdata[k]));
      if (lat_pend[k])
        chk(ovld[k] && odata[k] == lat_word[k], "R9", "next-cycle visibility",
            longint'(ovld[k]), 1);
      lat_pend[k] = 1'b0;
      if (ovld[k] && ordy[k]) begin
        if (expq[k].size() == 0)
          chk(1'b0, "R4", "unexpected output word", longint'(odata[k]), -1);
        else begin
          logic [W-1:0] e;
          e = expq[k].pop_front();
          chk(odata[k] == e, "R4", "output order", longint'(odata[k]), longint'(e));
        end
      end
      held[k]  = ovld[k] && !ordy[k];
      hdata[k] = odata[k];
      if (ivld[k] && irdy[k]) begin
        if (expq[k].size() == 0 && !(ovld[k] && ordy[k])) begin
          lat_pend[k] = 1'b1;
          lat_word[k] = idata[k];
        end
        expq[k].push_back(idata[k]);
        acc_now[k] = 1'b1;
        accn[k]++;
        if (chk_iv) begin
          if (lastc[k] >= 0) begin
            int d;
            d = cyc - lastc[k];
            if (k == 1)
              chk(d == LAT + 1, "R6", "one-lane capture spacing", d, LAT + 1);
            else begin
              chk((d == 1 || d == 2) && d != lastd[k], "R5",
                  "two-lane capture spacing alternates", d, (lastd[k] == 1) ? 2 : 1);
              lastd[k] = d;
            end
          end
          lastc[k] = cyc;
        end
      end
    end
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int n0, n1;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 2; k++) begin
      ivld[k] = 1'b0; ordy[k] = 1'b0; idata[k] = '0; seq[k] = 0;
      acc_now[k] = 1'b0; held[k] = 1'b0; lat_pend[k] = 1'b0;
      lastc[k] = -1; lastd[k] = 0; accn[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #5;
    for (int k = 0; k < 2; k++) begin
      chk(ovld[k] == 1'b0, "R1", "out_valid after reset", longint'(ovld[k]), 0);
      chk(irdy[k] == 1'b1, "R1", "in_ready after reset", longint'(irdy[k]), 1);
    end

    // R8: full stall, capacity per build
    n0 = accn[0]; n1 = accn[1];
    repeat (8) step(100, 0);
    chk(accn[0] - n0 == 2, "R8", "two-lane capacity", accn[0] - n0, 2);
    chk(accn[1] - n1 == 1, "R8", "one-lane capacity", accn[1] - n1, 1);
    chk(irdy[0] == 1'b0 && irdy[1] == 1'b0, "R8", "ready low when full",
        longint'(irdy[0]) + longint'(irdy[1]), 0);

    // drain
    src_on = 1'b0;
    repeat (12) step(0, 100);
    src_on = 1'b1;

    // R5/R6/R7: continuous stream
    chk_iv = 1'b1;
    n0 = accn[0]; n1 = accn[1];
    repeat (300) step(100, 100);
    chk_iv = 1'b0;
    chk((accn[0] - n0) >= 199 && (accn[0] - n0) <= 201, "R7",
        "two-lane words in 300 cycles", accn[0] - n0, 200);
    chk((accn[1] - n1) >= 99 && (accn[1] - n1) <= 101, "R7",
        "one-lane words in 300 cycles", accn[1] - n1, 100);

    // R2/R3/R4: random gaps and stalls
    repeat (3000) step(60, 60);

    // R4: final drain, nothing left behind
    src_on = 1'b0;
    repeat (30) step(0, 100);
    for (int k = 0; k < 2; k++) begin
      chk(expq[k].size() == 0, "R4", "words lost", expq[k].size(), 0);
      chk(ovld[k] == 1'b0, "R2", "valid low when empty", longint'(ovld[k]), 0);
    end
    report();
  end
endmodule